// File: doc/BRIEF.md
# Rotate Instruction Executor

This block carries out two byte rotate instructions for a small 8-bit accumulator core. The two instructions are a left rotate that ignores carry and a right rotate that passes through the carry flag. Each 16-bit instruction word is accepted once per instruction cycle. One instruction cycle is four clock phases: decode, read, process, write.

During decode the block forms a file address from the 8-bit register field. The address comes either from the access bank or from the current bank-select value. In the read phase it requests the operand from a register file whose read port is synchronous. In the process phase it rotates the byte. In the write phase it sends the result either to its working register or back to the file location. The C, N and Z flags are updated in the same write phase.

Any instruction word that is not one of the two rotates passes through its four phases and changes nothing. The core around this block supplies the instruction word and the bank-select value during the decode phase. It also provides a register file that returns read data one clock after a request and writes on the clock edge that ends the write phase.

Top module: `rot_exec`

## Requirements
- R1: While reset is asserted, and directly after it, `phase` is 0, `w` is 0x00, all three flags are 0, and neither `rf_re` nor `rf_we` is asserted.
- R2: `phase` steps 0,1,2,3 and then back to 0, one step per clock. `instr` and `bsr` are captured at the edge that ends phase 0. `rf_re` is asserted only in phase 1. `rf_we` is asserted only in phase 3.
- R3: An instruction with bits [15:10] = 010001 rotates left. The result is operand[6:0] followed by operand[7] in bit 0, so 0xAB gives 0x57. C is not changed.
- R4: An instruction with bits [15:10] = 001100 rotates right through carry. The result is {C, operand[7:1]}, and C takes operand[0]. For example, 0xE6 with C=0 gives 0x73 and C=0.
- R5: After either rotate, N equals result bit 7, and Z is 1 exactly when the result is 0x00.
- R6: When bit 9 (destination) is 0, `w` takes the result at the end of phase 3, and `rf_we` stays low for the whole instruction.
- R7: When bit 9 is 1, `rf_we` is high in phase 3 with `rf_wdata` equal to the result at the latched address, and `w` is left unchanged.
- R8: When bit 8 is 0, the address is {0x0, f} for f < 0x80 and {0xF, f} for f >= 0x80. Here f is bits [7:0].
- R9: When bit 8 is 1, the address is {bsr, f}.
- R10: A word that matches neither rotate pattern asserts neither `rf_re` nor `rf_we`, and leaves `w`, C, N and Z unchanged.
- R11: A result written in phase 3 is seen by the read in the very next instruction's phase 1, so chained rotates of one location compound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word, sampled at the end of phase 0 |
| bsr | input | BSR_W | Bank-select value, sampled at the end of phase 0 |
| rf_addr | output | BSR_W+8 | File address latched during decode |
| rf_re | output | 1 | Read request (phase 1) |
| rf_rdata | input | 8 | Read data, valid one clock after `rf_re` |
| rf_we | output | 1 | Write strobe (phase 3) |
| rf_wdata | output | 8 | Write data |
| w | output | 8 | Working register |
| c_flag | output | 1 | Carry flag |
| n_flag | output | 1 | Negative flag |
| z_flag | output | 1 | Zero flag |
| phase | output | 2 | Current phase, 0..3 |

## Verification
The bench builds the block with the default BSR_W of 4, which gives a 12-bit file address. With that address width, a full 4096-byte model of the file fits in the bench. That covers both halves of the access bank, including the high special-function area at 0xF80–0xFFF, and it also covers several bank-select values. Carry is carried through sequences of rotates. This exercises carry-in on the right rotate and carry retention on the left rotate.

// File: rtl/rot_exec.sv
module rot_exec #(
  parameter int BSR_W = 4,
  localparam int AW = BSR_W + 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      instr,
  input  logic [BSR_W-1:0] bsr,
  output logic [AW-1:0]    rf_addr,
  output logic             rf_re,
  input  logic [7:0]       rf_rdata,
  output logic             rf_we,
  output logic [7:0]       rf_wdata,
  output logic [7:0]       w,
  output logic             c_flag,
  output logic             n_flag,
  output logic             z_flag,
  output logic [1:0]       phase
);

  localparam logic [5:0] OP_ROL = 6'b010001;
  localparam logic [5:0] OP_ROR = 6'b001100;

  logic [5:0]    op_q;
  logic          to_file_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    res_q;
  logic          cout_q;
  logic [AW-1:0] addr_d;

  wire is_rol = (op_q == OP_ROL);
  wire is_ror = (op_q == OP_ROR);
  wire is_rot = is_rol | is_ror;

  always_comb begin
    if (instr[8])
      addr_d = {bsr, instr[7:0]};
    else if (instr[7])
      addr_d = {{BSR_W{1'b1}}, instr[7:0]};
    else
      addr_d = {{BSR_W{1'b0}}, instr[7:0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= 2'd0;
      op_q      <= 6'd0;
      to_file_q <= 1'b0;
      addr_q    <= '0;
      res_q     <= 8'd0;
      cout_q    <= 1'b0;
      w         <= 8'd0;
      c_flag    <= 1'b0;
      n_flag    <= 1'b0;
      z_flag    <= 1'b0;
    end else begin
      phase <= phase + 2'd1;
      case (phase)
        2'd0: begin
          op_q      <= instr[15:10];
          to_file_q <= instr[9];
          addr_q    <= addr_d;
        end
        2'd2: begin
          if (is_rol) begin
            res_q  <= {rf_rdata[6:0], rf_rdata[7]};
            cout_q <= c_flag;
          end else begin
            res_q  <= {c_flag, rf_rdata[7:1]};
            cout_q <= rf_rdata[0];
          end
        end
        2'd3: begin
          if (is_rot) begin
            if (!to_file_q) w <= res_q;
            n_flag <= res_q[7];
            z_flag <= (res_q == 8'd0);
            if (is_ror) c_flag <= cout_q;
          end
        end
        default: ;
      endcase
    end
  end

  assign rf_addr  = addr_q;
  assign rf_re    = rst_n && (phase == 2'd1) && is_rot;
  assign rf_we    = rst_n && (phase == 2'd3) && is_rot && to_file_q;
  assign rf_wdata = res_q;

  a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd3 |=> phase == 2'd0);
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    phase != 2'd3 |=> phase == 2'($past(phase) + 2'd1));
  a_r2_re_q2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |-> phase == 2'd1);
  a_r2_we_q4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> phase == 2'd3);
  a_r3_carry_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && is_rol) |=> $stable(c_flag));
  a_r7_w_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && to_file_q) |=> $stable(w));
  a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && !is_rot) |=> ($stable(w) && $stable(c_flag) && $stable(n_flag) && $stable(z_flag)));
  a_r5_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 2'd3 && is_rot) |=> (z_flag == (w == 8'd0) || to_file_q));

endmodule

// File: tb/rot_exec_bench.sv
module rot_exec_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = 16'h0000;
  logic [3:0]  bsr = 4'h0;
  logic [11:0] rf_addr;
  logic        rf_re, rf_we;
  logic [7:0]  rf_rdata, rf_wdata, w;
  logic        c_flag, n_flag, z_flag;
  logic [1:0]  phase;

  logic [7:0] mem [0:4095];
  logic [7:0] rdq = 8'h00;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rf_we) mem[rf_addr] <= rf_wdata;
    if (rf_re) rdq <= mem[rf_addr];
  end
  assign rf_rdata = rdq;

  rot_exec #(.BSR_W(4)) u_rot_exec (
    .clk(clk), .rst_n(rst_n), .instr(instr), .bsr(bsr),
    .rf_addr(rf_addr), .rf_re(rf_re), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_wdata(rf_wdata), .w(w),
    .c_flag(c_flag), .n_flag(n_flag), .z_flag(z_flag), .phase(phase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  logic        s_re, s_we;
  logic [11:0] s_raddr, s_waddr;
  logic [7:0]  s_wdata;

  task automatic exec(input logic [15:0] iw, input logic [3:0] b);
    instr = iw; bsr = b;
    s_re = 0; s_we = 0;
    @(negedge clk);
    s_re = rf_re; s_raddr = rf_addr;
    if (rf_we) s_we = 1;
    @(negedge clk);
    if (rf_re) s_re = 0;
    if (rf_we) s_we = 1;
    @(negedge clk);
    if (rf_re) s_re = 0;
    s_we = rf_we; s_waddr = rf_addr; s_wdata = rf_wdata;
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(phase == 0, "R1 phase", phase, 0);
    check(w == 0, "R1 w", w, 0);
    check({c_flag, n_flag, z_flag} == 3'b000, "R1 flags", {c_flag, n_flag, z_flag}, 0);
    check(!rf_re && !rf_we, "R1 strobes", {rf_re, rf_we}, 0);
  endtask

  task automatic t_rol_to_w;
    mem[12'h020] = 8'hAB;
    exec(16'h4420, 4'h0);
    check(s_re && s_raddr == 12'h020, "R8 read addr", s_raddr, 12'h020);
    check(w == 8'h57, "R3 rol result", w, 8'h57);
    check(!s_we, "R6 no file write", s_we, 0);
    check(n_flag == 0 && z_flag == 0, "R5 flags", {n_flag, z_flag}, 0);
    check(c_flag == 0, "R3 carry kept", c_flag, 0);
  endtask

  task automatic t_ror_to_file;
    mem[12'h021] = 8'hE6;
    exec(16'h3221, 4'h0);
    check(s_we && s_waddr == 12'h021, "R7 write addr", s_waddr, 12'h021);
    check(s_wdata == 8'h73, "R4 ror result", s_wdata, 8'h73);
    check(w == 8'h57, "R7 w unchanged", w, 8'h57);
    check(c_flag == 0 && n_flag == 0 && z_flag == 0, "R4 flags", {c_flag, n_flag, z_flag}, 0);
  endtask

  task automatic t_ror_carry;
    mem[12'h022] = 8'h01;
    exec(16'h3022, 4'h0);
    check(w == 8'h00 && z_flag && c_flag && !n_flag, "R5 zero+carry", {w, c_flag, n_flag, z_flag}, 12'h005);
    mem[12'h023] = 8'h80;
    exec(16'h3023, 4'h0);
    check(w == 8'hC0, "R4 carry in", w, 8'hC0);
    check(!c_flag && n_flag && !z_flag, "R5 negative", {c_flag, n_flag, z_flag}, 3'b010);
  endtask

  task automatic t_rol_keeps_carry;
    mem[12'h024] = 8'h01;
    exec(16'h3024, 4'h0);
    mem[12'h025] = 8'h80;
    exec(16'h4425, 4'h0);
    check(w == 8'h01, "R3 wrap bit7", w, 8'h01);
    check(c_flag == 1, "R3 carry kept set", c_flag, 1);
  endtask

  task automatic t_access_high;
    mem[12'hF85] = 8'h3C;
    exec(16'h4685, 4'h7);
    check(s_raddr == 12'hF85, "R8 sfr read", s_raddr, 12'hF85);
    check(s_we && s_waddr == 12'hF85 && s_wdata == 8'h78, "R8 sfr write", s_wdata, 8'h78);
  endtask

  task automatic t_bank_select;
    mem[12'h510] = 8'h11;
    exec(16'h4710, 4'h5);
    check(s_raddr == 12'h510 && s_waddr == 12'h510, "R9 bank 5", s_waddr, 12'h510);
    mem[12'h290] = 8'h00;
    exec(16'h4590, 4'h2);
    check(s_raddr == 12'h290 && z_flag, "R9 bank 2 high f", s_raddr, 12'h290);
  endtask

  task automatic t_nop;
    logic [7:0] w0;
    logic [2:0] f0;
    mem[12'h030] = 8'h55;
    exec(16'h3022, 4'h0);
    w0 = w; f0 = {c_flag, n_flag, z_flag};
    exec(16'h3830, 4'h0);
    check(!s_re && !s_we, "R10 no access", {s_re, s_we}, 0);
    check(w == w0 && {c_flag, n_flag, z_flag} == f0, "R10 state kept", {w, c_flag, n_flag, z_flag}, {w0, f0});
    exec(16'hFFFF, 4'hF);
    check(!s_we && w == w0 && {c_flag, n_flag, z_flag} == f0, "R10 all ones", w, w0);
  endtask

  task automatic t_chain;
    mem[12'h031] = 8'h81;
    exec(16'h4631, 4'h0);
    check(s_wdata == 8'h03, "R11 first", s_wdata, 8'h03);
    exec(16'h4631, 4'h0);
    check(s_wdata == 8'h06, "R11 second sees write", s_wdata, 8'h06);
    check(mem[12'h031] == 8'h06, "R11 memory", mem[12'h031], 8'h06);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    check(phase == 0, "R2 start phase", phase, 0);
    t_rol_to_w();
    t_ror_to_file();
    t_ror_carry();
    t_rol_keeps_carry();
    t_access_high();
    t_bank_select();
    t_nop();
    t_chain();
    check(phase == 0, "R2 phase aligned", phase, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule